// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers eleven serial-port interrupt causes into a single status word and a single interrupt line. Eight of the causes are one-cycle events: the four modem-line changes (ring indicator, clear-to-send, carrier detect, data-set-ready) and the four receive errors (framing, parity, break, overrun). Each event latches a sticky raw bit that stays set until software clears it. Three causes are levels: receive-level, transmit-level and receive-timeout. Their raw bits track the input directly.

Software programs an enable mask and reads back both the raw status and the masked status. It acknowledges sticky causes by writing ones to a dedicated clear register. The interrupt output is asserted whenever any masked bit is set. The register port is a simple word port. A write takes effect at the clock edge. A read returns data combinationally from the selected word.

Top module: `irq_status_ctrl`

## Requirements
- R1: Every status and mask word uses this bit position per cause: ring indicator 0, clear-to-send 1, carrier detect 2, data-set-ready 3, receive level 4, transmit level 5, receive timeout 6, framing error 7, parity error 8, break 9, overrun 10.
- R2: The word at `addr` 2 reads the raw status ANDed with the mask.
- R3: A one-cycle pulse on an event input (bits 0-3 and 7-10 of `src_i`) sets its raw bit at the next clock edge. The bit then holds until it is cleared. The raw status reads at `addr` 1.
- R4: Writing a word to `addr` 3 clears each sticky raw bit whose data bit is one. Writing 0x7FF clears every sticky bit. The other bits keep their state. `addr` 3 reads as zero.
- R5: Raw bits 4, 5 and 6 equal `src_i` bits 4, 5 and 6 in the same cycle. A write to the clear register does not change them.
- R6: `irq_o` is high exactly when at least one masked status bit is one.
- R7: If an event pulse and a clear write reach the same sticky bit in the same cycle, the bit ends up set.
- R8: Read data bits 31 to 11 are always zero. Mask write data above bit 10 is discarded.
- R9: After reset the mask is zero, all sticky raw bits are zero and `irq_o` is low.
- R10: The word at `addr` 0 is read/write and holds the mask written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 11 | Cause inputs: event pulses on sticky bits, levels on bits 4-6 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word select: 0 mask, 1 raw, 2 masked, 3 clear |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The assertions assume that event causes arrive as single-cycle pulses. They also assume that a write cycle presents a stable `addr` and `wr_data`. They do not assume that events and clears are kept apart: the set-over-clear rule is checked for any overlap. The stimulus drives every input on the falling edge and releases each event after one cycle. It collides an event with a clear on purpose only to exercise the priority rule. Level inputs are held across many cycles, including across clear writes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_COUNT = 11;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_RAW    = 2'd1,
    SEL_ACTIVE = 2'd2,
    SEL_ACK    = 2'd3
  } reg_sel_e;

  // Bits whose raw status follows the input level rather than latching.
  localparam logic [SRC_COUNT-1:0] LEVEL_SEL_DEFAULT = 11'b000_0111_0000;
endpackage

// File: rtl/irqc_raw_status.sv
module irqc_raw_status #(
  parameter int                N_SRC     = 11,
  parameter logic [N_SRC-1:0]  LEVEL_SEL = 11'b000_0111_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] ack_bits,
  output logic [N_SRC-1:0] raw_o,
  output logic [N_SRC-1:0] set_evt
);
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (LEVEL_SEL[i]) begin : g_level
      assign set_evt[i] = 1'b0;
      assign raw_o[i]   = src_i[i];
    end else begin : g_sticky
      logic q;
      assign set_evt[i] = src_i[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= sticky_next(q, set_evt[i], ack_bits[i]);
      end
      assign raw_o[i] = q;
    end
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_SRC-1:0]  raw_i,
  output logic [N_SRC-1:0]  mask_o,
  output logic [N_SRC-1:0]  active_o,
  output logic [N_SRC-1:0]  ack_bits,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - N_SRC;

  function automatic logic [N_SRC-1:0] gate_status(input logic [N_SRC-1:0] raw,
                                                   input logic [N_SRC-1:0] en);
    return raw & en;
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [N_SRC-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  logic [N_SRC-1:0] mask_q;
  logic             mask_we;
  reg_sel_e         sel;

  assign sel      = reg_sel_e'(addr);
  assign mask_we  = wr_en && (sel == SEL_ENABLE);
  assign ack_bits = (wr_en && (sel == SEL_ACK)) ? wr_data[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wr_data[N_SRC-1:0];
  end

  assign mask_o   = mask_q;
  assign active_o = gate_status(raw_i, mask_q);

  always_comb begin
    case (sel)
      SEL_ENABLE: rd_data = widen(mask_q);
      SEL_RAW:    rd_data = widen(raw_i);
      SEL_ACTIVE: rd_data = widen(active_o);
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqc_pkg::*;
#(
  parameter int                N_SRC     = SRC_COUNT,
  parameter int                DATA_W    = 32,
  parameter logic [N_SRC-1:0]  LEVEL_SEL = LEVEL_SEL_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  logic [N_SRC-1:0] raw_w;
  logic [N_SRC-1:0] mask_w;
  logic [N_SRC-1:0] active_w;
  logic [N_SRC-1:0] ack_w;
  logic [N_SRC-1:0] set_w;

  irqc_raw_status #(.N_SRC(N_SRC), .LEVEL_SEL(LEVEL_SEL)) u_raw (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .ack_bits (ack_w),
    .raw_o    (raw_w),
    .set_evt  (set_w)
  );

  irqc_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .raw_i    (raw_w),
    .mask_o   (mask_w),
    .active_o (active_w),
    .ack_bits (ack_w),
    .rd_data  (rd_data)
  );

  assign irq_o = |active_w;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int                N_SRC     = 11,
  parameter int                DATA_W    = 32,
  parameter logic [N_SRC-1:0]  LEVEL_SEL = 11'b000_0111_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  src_i,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_o,
  input logic [N_SRC-1:0]  raw,
  input logic [N_SRC-1:0]  mask
);
  localparam logic [N_SRC-1:0] STICKY = ~LEVEL_SEL;
  logic [N_SRC-1:0] clr_req;
  logic [N_SRC-1:0] evt;
  assign clr_req = (wr_en && addr == 2'd3) ? wr_data[N_SRC-1:0] : '0;
  assign evt     = src_i & STICKY;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((raw & $past(evt)) == $past(evt))); // R7

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(raw & STICKY & ~clr_req)) == $past(raw & STICKY & ~clr_req))); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_req & STICKY & ~evt)) |=> ((raw & $past(clr_req & STICKY & ~evt)) == '0)); // R4

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (raw & LEVEL_SEL) == (src_i & LEVEL_SEL)); // R5

  AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o); // R6

  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|raw)); // R6

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:N_SRC] == '0); // R8

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> (mask == $past(wr_data[N_SRC-1:0]))); // R10
endmodule

bind irq_status_ctrl irqc_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .LEVEL_SEL(LEVEL_SEL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .src_i   (src_i),
  .wr_en   (wr_en),
  .addr    (addr),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .irq_o   (irq_o),
  .raw     (raw_w),
  .mask    (mask_w)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  logic [10:0] lvl = '0;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  localparam logic [10:0] EVT_BITS = 11'h78F;
  localparam logic [10:0] LVL_BITS = 11'h070;

  irq_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total = total + 1;
    if (got !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    src_i = lvl; wr_en = 1'b0; addr = a;
    #1 d = rd_data;
  endtask

  // One clock of activity: optional write and optional event pulse.
  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic [10:0] evt);
    @(negedge clk);
    wr_en = we; addr = a; wr_data = d; src_i = lvl | (evt & EVT_BITS);
    @(negedge clk);
    wr_en = 1'b0; src_i = lvl;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    rd(2'd0, v); chk("R9 mask after reset", v, 32'h0);
    rd(2'd1, v); chk("R9 raw after reset", v, 32'h0);
    rd(2'd2, v); chk("R9 masked after reset", v, 32'h0);
    chk("R9 irq after reset", {31'b0, irq_o}, 32'h0);

    // R1/R3/R4 each sticky bit position
    for (int i = 0; i < 11; i++) begin
      if (EVT_BITS[i]) begin
        step(1'b0, 2'd0, 32'h0, 11'(1 << i));
        rd(2'd1, v); chk("R1 R3 event sets own bit", v, 32'(1 << i));
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R3 event bit holds", v, 32'(1 << i));
        step(1'b1, 2'd3, 32'h7FF & ~32'(1 << i), 11'h0);
        rd(2'd1, v); chk("R4 clear of other bits leaves bit", v, 32'(1 << i));
        step(1'b1, 2'd3, 32'(1 << i), 11'h0);
        rd(2'd1, v); chk("R4 clear own bit", v, 32'h0);
      end
    end

    // R5 level bits
    for (int i = 4; i < 7; i++) begin
      lvl = 11'(1 << i);
      rd(2'd1, v); chk("R5 R1 level bit follows input", v, 32'(1 << i));
      step(1'b1, 2'd3, 32'h7FF, 11'h0);
      rd(2'd1, v); chk("R5 clear ignored on level bit", v, 32'(1 << i));
      lvl = '0;
      rd(2'd1, v); chk("R5 level bit drops", v, 32'h0);
    end

    // R4 partial and full clear
    step(1'b0, 2'd0, 32'h0, EVT_BITS);
    rd(2'd1, v); chk("R3 all events set", v, 32'h78F);
    step(1'b1, 2'd3, 32'h00F, 11'h0);
    rd(2'd1, v); chk("R4 partial clear", v, 32'h780);
    rd(2'd3, v); chk("R4 clear word reads zero", v, 32'h0);
    step(1'b1, 2'd3, 32'h7FF, 11'h0);
    rd(2'd1, v); chk("R4 0x7FF clears all", v, 32'h0);

    // R7 set beats clear
    step(1'b0, 2'd0, 32'h0, 11'h100);
    step(1'b1, 2'd3, 32'h300, 11'h200);
    rd(2'd1, v); chk("R7 set wins over clear", v, 32'h200);
    step(1'b1, 2'd3, 32'h7FF, 11'h0);

    // R6 irq on a level source through the mask
    step(1'b1, 2'd0, 32'h010, 11'h0);
    rd(2'd2, v); chk("R6 masked idle", v, 32'h0);
    chk("R6 irq low with no cause", {31'b0, irq_o}, 32'h0);
    lvl = 11'h010;
    rd(2'd2, v); chk("R2 masked level", v, 32'h010);
    chk("R6 irq from level", {31'b0, irq_o}, 32'h1);
    lvl = 11'h060;
    rd(2'd2, v); chk("R2 unmasked level hidden", v, 32'h0);
    chk("R6 irq low when cause masked", {31'b0, irq_o}, 32'h0);

    // Full mask sweep with all causes raised: R2 R6 R8 R10
    lvl = LVL_BITS;
    step(1'b0, 2'd0, 32'h0, EVT_BITS);
    for (int m = 0; m < 2048; m++) begin
      step(1'b1, 2'd0, 32'hFFFF_F800 | 32'(m), 11'h0);
      rd(2'd0, v); chk("R10 R8 mask readback", v, 32'(m));
      rd(2'd2, v); chk("R2 masked equals mask", v, 32'(m));
      chk("R6 irq equals any masked", {31'b0, irq_o}, {31'b0, (m != 0)});
    end
    rd(2'd1, v); chk("R8 raw upper bits zero", v, 32'h7FF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule